// File: doc/BRIEF.md
# Per-Target Interrupt Priority Arbiter

This block sits between the pending-interrupt state of an interrupt controller and its targets. For every target it looks at the sources that are pending and enabled for that target. It discards any source whose priority does not beat the target's threshold. From the sources that remain it picks the one with the highest priority. The result is presented as a registered interrupt line and a registered identifier, which software reads to claim the interrupt.

Sources are numbered from 1. Identifier 0 is reserved and means that nothing is eligible. The arbitration is recomputed from the inputs on every clock, with no memory of earlier winners. A claim therefore shows up only through the pending vector: once the gateway logic clears the claimed source, the next cycle's result moves to the next eligible source, or to 0.

Top module: `plic_arb_top`

## Requirements
- R1: Among the sources eligible for a target, the one with the numerically largest priority field wins; source k's priority is `prio_i[(k-1)*PW +: PW]`.
- R2: When several eligible sources share the top priority, the one with the smallest source number wins.
- R3: Source k is considered for target t only when `en_i[t*N_SRC + k-1]` is 1. A disabled source has no effect on that target, even when its priority is higher.
- R4: With the threshold check built in, a source is eligible only if its priority is strictly greater than `thresh_i[t*PW +: PW]`. A threshold of 0 masks nothing.
- R5: A source whose priority is 0 is never eligible.
- R6: `id_o[t*IW +: IW]` carries the winning source number, counted from 1. It carries 0 when no source is eligible, and it never exceeds N_SRC.
- R7: `irq_o[t]` is 1 exactly when some source is eligible for target t. When the winner stops pending, the line stays high only if another eligible source remains, and the identifier moves to that source.
- R8: Outputs are registered. A change on any input appears on `irq_o`/`id_o` after the next rising clock edge and not before it.
- R9: While `rst_ni` is low, every `irq_o` bit and every `id_o` field is 0, regardless of the inputs. This takes effect without waiting for a clock edge.
- R10: With THRESH_EN = 0 the threshold inputs are ignored, and every pending, enabled source with a nonzero priority is eligible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pend_i | input | N_SRC | Pending flags; bit k-1 belongs to source k |
| prio_i | input | N_SRC*PW | Priority field per source, PW = clog2(N_LEVELS+1) |
| en_i | input | N_TGT*N_SRC | Enable matrix; N_SRC bits per target |
| thresh_i | input | N_TGT*PW | Priority threshold per target |
| irq_o | output | N_TGT | Interrupt line per target |
| id_o | output | N_TGT*IW | Winning source number per target, IW = clog2(N_SRC+1) |

## Verification
The bench builds two copies of the block, each with 5 sources, 2 targets and 7 priority levels; one has the threshold check and the other does not. Five sources is not a power of two, so the padded leaves of the comparison tree are exercised. A 3-bit priority lets the tests reach both the maximum level and the zero level. Two targets given different enable masks and thresholds show that each target is arbitrated independently. Driving the same stimulus into the copy without the threshold check covers the parameter variant: rows that are masked by the threshold in the first copy still produce a winner in the second.

// File: rtl/plic_arb_pkg.sv
package plic_arb_pkg;

  function automatic int prio_width(int levels);
    return (levels < 1) ? 1 : $clog2(levels + 1);
  endfunction

  function automatic int id_width(int n_src);
    return $clog2(n_src + 1);
  endfunction

endpackage

// File: rtl/plic_arb_elig.sv
module plic_arb_elig #(
  parameter int N_SRC     = 16,
  parameter int PW        = 4,
  parameter bit THRESH_EN = 1'b1
) (
  input  logic [N_SRC-1:0]    pend_i,
  input  logic [N_SRC-1:0]    en_i,
  input  logic [N_SRC*PW-1:0] prio_i,
  input  logic [PW-1:0]       thresh_i,
  output logic [N_SRC-1:0]    elig_o
);

  logic [PW-1:0] thr_eff;

  // disabled threshold behaves as threshold 0: priority 0 still never qualifies
  assign thr_eff = THRESH_EN ? thresh_i : '0;

  for (genvar s = 0; s < N_SRC; s++) begin : g_src
    assign elig_o[s] = pend_i[s] & en_i[s] & (prio_i[s*PW +: PW] > thr_eff);
  end

endmodule

// File: rtl/plic_arb_tree.sv
module plic_arb_tree #(
  parameter int N_SRC = 16,
  parameter int PW    = 4,
  parameter int IW    = 5
) (
  input  logic [N_SRC-1:0]    elig_i,
  input  logic [N_SRC*PW-1:0] prio_i,
  output logic                win_v_o,
  output logic [PW-1:0]       win_p_o,
  output logic [IW-1:0]       win_id_o
);

  localparam int LVL    = (N_SRC > 1) ? $clog2(N_SRC) : 0;
  localparam int LEAVES = 1 << LVL;

  for (genvar l = 0; l <= LVL; l++) begin : g_lvl
    localparam int W = LEAVES >> l;
    logic          v  [W];
    logic [PW-1:0] p  [W];
    logic [IW-1:0] id [W];

    if (l == 0) begin : g_leaf
      for (genvar i = 0; i < W; i++) begin : g_i
        if (i < N_SRC) begin : g_real
          assign v[i]  = elig_i[i];
          assign p[i]  = prio_i[i*PW +: PW];
          assign id[i] = IW'(i + 1);
        end else begin : g_pad
          assign v[i]  = 1'b0;
          assign p[i]  = '0;
          assign id[i] = '0;
        end
      end
    end else begin : g_node
      for (genvar i = 0; i < W; i++) begin : g_i
        logic take_l;
        // left child always holds the lower source numbers: >= keeps ties there
        assign take_l = g_lvl[l-1].v[2*i] &&
                        (!g_lvl[l-1].v[2*i+1] ||
                         (g_lvl[l-1].p[2*i] >= g_lvl[l-1].p[2*i+1]));
        assign v[i]  = g_lvl[l-1].v[2*i] | g_lvl[l-1].v[2*i+1];
        assign p[i]  = take_l ? g_lvl[l-1].p[2*i]  : g_lvl[l-1].p[2*i+1];
        assign id[i] = take_l ? g_lvl[l-1].id[2*i] : g_lvl[l-1].id[2*i+1];
      end
    end
  end

  assign win_v_o  = g_lvl[LVL].v[0];
  assign win_p_o  = g_lvl[LVL].p[0];
  assign win_id_o = g_lvl[LVL].id[0];

endmodule

// File: rtl/plic_arb_target.sv
module plic_arb_target #(
  parameter int N_SRC     = 16,
  parameter int PW        = 4,
  parameter int IW        = 5,
  parameter bit THRESH_EN = 1'b1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N_SRC-1:0]    pend_i,
  input  logic [N_SRC-1:0]    en_i,
  input  logic [N_SRC*PW-1:0] prio_i,
  input  logic [PW-1:0]       thresh_i,
  output logic                irq_o,
  output logic [IW-1:0]       id_o
);

  logic [N_SRC-1:0] elig;
  logic             win_v;
  logic [PW-1:0]    win_p;
  logic [IW-1:0]    win_id;
  logic             irq_d;
  logic [IW-1:0]    id_d;

  plic_arb_elig #(
    .N_SRC(N_SRC), .PW(PW), .THRESH_EN(THRESH_EN)
  ) u_elig (
    .pend_i  (pend_i),
    .en_i    (en_i),
    .prio_i  (prio_i),
    .thresh_i(thresh_i),
    .elig_o  (elig)
  );

  plic_arb_tree #(
    .N_SRC(N_SRC), .PW(PW), .IW(IW)
  ) u_tree (
    .elig_i  (elig),
    .prio_i  (prio_i),
    .win_v_o (win_v),
    .win_p_o (win_p),
    .win_id_o(win_id)
  );

  assign irq_d = win_v && (win_p != '0);
  assign id_d  = irq_d ? win_id : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o <= 1'b0;
      id_o  <= '0;
    end else begin
      irq_o <= irq_d;
      id_o  <= id_d;
    end
  end

endmodule

// File: rtl/plic_arb_top.sv
module plic_arb_top
  import plic_arb_pkg::*;
#(
  parameter int N_SRC     = 16,
  parameter int N_TGT     = 4,
  parameter int N_LEVELS  = 8,
  parameter bit THRESH_EN = 1'b1,
  localparam int PW       = prio_width(N_LEVELS),
  localparam int IW       = id_width(N_SRC)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N_SRC-1:0]       pend_i,
  input  logic [N_SRC*PW-1:0]    prio_i,
  input  logic [N_TGT*N_SRC-1:0] en_i,
  input  logic [N_TGT*PW-1:0]    thresh_i,
  output logic [N_TGT-1:0]       irq_o,
  output logic [N_TGT*IW-1:0]    id_o
);

  for (genvar t = 0; t < N_TGT; t++) begin : g_tgt
    plic_arb_target #(
      .N_SRC(N_SRC), .PW(PW), .IW(IW), .THRESH_EN(THRESH_EN)
    ) u_tgt (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .pend_i  (pend_i),
      .en_i    (en_i[t*N_SRC +: N_SRC]),
      .prio_i  (prio_i),
      .thresh_i(thresh_i[t*PW +: PW]),
      .irq_o   (irq_o[t]),
      .id_o    (id_o[t*IW +: IW])
    );
  end

endmodule

// File: rtl/plic_arb_chk.sv
module plic_arb_chk #(
  parameter int N_SRC     = 16,
  parameter int N_TGT     = 4,
  parameter int PW        = 4,
  parameter int IW        = 5,
  parameter bit THRESH_EN = 1'b1
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [N_SRC-1:0]       pend_i,
  input logic [N_SRC*PW-1:0]    prio_i,
  input logic [N_TGT*N_SRC-1:0] en_i,
  input logic [N_TGT*PW-1:0]    thresh_i,
  input logic [N_TGT-1:0]       irq_o,
  input logic [N_TGT*IW-1:0]    id_o
);

  logic                   seen;
  logic [N_SRC-1:0]       pend_q;
  logic [N_SRC*PW-1:0]    prio_q;
  logic [N_TGT*N_SRC-1:0] en_q;
  logic [N_TGT*PW-1:0]    thr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen   <= 1'b0;
      pend_q <= '0;
      prio_q <= '0;
      en_q   <= '0;
      thr_q  <= '0;
    end else begin
      seen   <= 1'b1;
      pend_q <= pend_i;
      prio_q <= prio_i;
      en_q   <= en_i;
      thr_q  <= thresh_i;
    end
  end

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_quiet_R9: assert (irq_o == '0 && id_o == '0)
        else $error("outputs active during reset");
    end
  end

  for (genvar t = 0; t < N_TGT; t++) begin : g_t
    logic [PW-1:0]    thr_eff;
    logic [PW-1:0]    win_p;
    logic             win_pend;
    logic             win_en;
    logic [N_SRC-1:0] elig_q;
    logic [IW-1:0]    id_t;

    assign id_t    = id_o[t*IW +: IW];
    assign thr_eff = THRESH_EN ? thr_q[t*PW +: PW] : '0;

    always_comb begin
      win_p    = '0;
      win_pend = 1'b0;
      win_en   = 1'b0;
      for (int s = 0; s < N_SRC; s++) begin
        elig_q[s] = pend_q[s] & en_q[t*N_SRC+s] & (prio_q[s*PW +: PW] > thr_eff);
        if (id_t == IW'(s + 1)) begin
          win_p    = prio_q[s*PW +: PW];
          win_pend = pend_q[s];
          win_en   = en_q[t*N_SRC+s];
        end
      end
    end

    assert_id_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      id_t <= IW'(N_SRC));

    assert_irq_id_pair_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[t] == (id_t != '0));

    assert_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (seen && elig_q == '0) |-> !irq_o[t]);

    assert_no_pend_next_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend_i == '0) |=> !irq_o[t]);

    assert_winner_enabled_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (seen && irq_o[t]) |-> (win_pend && win_en));

    assert_winner_above_thr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (seen && irq_o[t]) |-> (win_p > thr_eff));

    assert_winner_nonzero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (seen && irq_o[t]) |-> (win_p != '0));

    for (genvar s = 0; s < N_SRC; s++) begin : g_s
      assert_top_prio_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seen && elig_q[s]) |-> (irq_o[t] && prio_q[s*PW +: PW] <= win_p));

      assert_tie_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seen && elig_q[s] && prio_q[s*PW +: PW] == win_p) |-> (IW'(s + 1) >= id_t));
    end
  end

endmodule

bind plic_arb_top plic_arb_chk #(
  .N_SRC(N_SRC), .N_TGT(N_TGT), .PW(PW), .IW(IW), .THRESH_EN(THRESH_EN)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .pend_i  (pend_i),
  .prio_i  (prio_i),
  .en_i    (en_i),
  .thresh_i(thresh_i),
  .irq_o   (irq_o),
  .id_o    (id_o)
);

// File: tb/tb_plic_arb_top.sv
`timescale 1ns/1ps
module tb_plic_arb_top;

  localparam int NS = 5;
  localparam int NT = 2;
  localparam int PW = 3;
  localparam int IW = 3;

  typedef struct packed {
    logic [NS-1:0]    pend;
    logic [NS*PW-1:0] prio;
    logic [NT*NS-1:0] en;
    logic [NT*PW-1:0] thr;
    logic [IW-1:0]    id0;
    logic [IW-1:0]    id1;
  } vec_t;

  // prio packed {p5,p4,p3,p2,p1}; en {t1,t0}; thr {t1,t0}
  localparam int NV = 9;
  localparam vec_t TAB [NV] = '{
    '{5'b00000, {5{3'd1}},                         10'h3FF,              {3'd0,3'd0}, 3'd0, 3'd0},
    '{5'b00001, {3'd1,3'd1,3'd1,3'd1,3'd3},        {5'b00000,5'b11111},  {3'd0,3'd0}, 3'd1, 3'd0},
    '{5'b10110, {3'd4,3'd1,3'd4,3'd4,3'd1},        10'h3FF,              {3'd0,3'd0}, 3'd2, 3'd2},
    '{5'b11111, {3'd6,3'd6,3'd3,3'd2,3'd1},        {5'b10111,5'b11111},  {3'd0,3'd0}, 3'd4, 3'd5},
    '{5'b00011, {3'd1,3'd1,3'd1,3'd5,3'd3},        10'h3FF,              {3'd3,3'd5}, 3'd0, 3'd2},
    '{5'b00110, {3'd1,3'd1,3'd4,3'd2,3'd1},        10'h3FF,              {3'd4,3'd3}, 3'd3, 3'd0},
    '{5'b11111, {5{3'd0}},                         10'h3FF,              {3'd0,3'd0}, 3'd0, 3'd0},
    '{5'b10000, {3'd7,3'd1,3'd1,3'd1,3'd1},        10'h3FF,              {3'd7,3'd6}, 3'd5, 3'd0},
    '{5'b00011, {3'd1,3'd1,3'd1,3'd7,3'd2},        {5'b00011,5'b00001},  {3'd0,3'd0}, 3'd1, 3'd2}
  };

  logic             clk;
  logic             rst_n;
  logic [NS-1:0]    pend;
  logic [NS*PW-1:0] prio;
  logic [NT*NS-1:0] en;
  logic [NT*PW-1:0] thr;
  logic [NT-1:0]    irq, irq_nt;
  logic [NT*IW-1:0] id, id_nt;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;
  string tag [NV];

  plic_arb_top #(.N_SRC(NS), .N_TGT(NT), .N_LEVELS(7), .THRESH_EN(1'b1)) dut (
    .clk_i(clk), .rst_ni(rst_n), .pend_i(pend), .prio_i(prio),
    .en_i(en), .thresh_i(thr), .irq_o(irq), .id_o(id)
  );

  plic_arb_top #(.N_SRC(NS), .N_TGT(NT), .N_LEVELS(7), .THRESH_EN(1'b0)) dut_nt (
    .clk_i(clk), .rst_ni(rst_n), .pend_i(pend), .prio_i(prio),
    .en_i(en), .thresh_i(thr), .irq_o(irq_nt), .id_o(id_nt)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [IW-1:0] model(input logic [NS-1:0] p_v, input logic [NS*PW-1:0] pr,
                                          input logic [NS-1:0] e, input logic [PW-1:0] th,
                                          input bit use_thr);
    logic [IW-1:0] best = '0;
    logic [PW-1:0] bp   = '0;
    logic [PW-1:0] lim  = use_thr ? th : '0;
    for (int s = 0; s < NS; s++) begin
      if (p_v[s] && e[s] && pr[s*PW +: PW] > lim && (best == '0 || pr[s*PW +: PW] > bp)) begin
        best = IW'(s + 1);
        bp   = pr[s*PW +: PW];
      end
    end
    return best;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_both(input string req, input int e0, input int e1);
    chk(req, "id t0", int'(id[0 +: IW]), e0);
    chk(req, "id t1", int'(id[IW +: IW]), e1);
    chk(req, "irq t0", int'(irq[0]), int'(e0 != 0));
    chk(req, "irq t1", int'(irq[1]), int'(e1 != 0));
  endtask

  task automatic check_nt(input string req);
    chk(req, "nothr id t0", int'(id_nt[0 +: IW]), int'(model(pend, prio, en[0 +: NS], thr[0 +: PW], 1'b0)));
    chk(req, "nothr id t1", int'(id_nt[IW +: IW]), int'(model(pend, prio, en[NS +: NS], thr[PW +: PW], 1'b0)));
  endtask

  task automatic drive(input logic [NS-1:0] p_v, input logic [NS*PW-1:0] pr,
                       input logic [NT*NS-1:0] e, input logic [NT*PW-1:0] th);
    pend = p_v; prio = pr; en = e; thr = th;
  endtask

  initial begin
    tag = '{"R6", "R3", "R2", "R1", "R4", "R4", "R5", "R4", "R3"};
    rst_n = 1'b0;
    drive('1, {NS{3'd7}}, '1, '0);
    repeat (3) @(negedge clk);
    // R9: active inputs held under reset produce nothing
    check_both("R9", 0, 0);

    rst_n = 1'b1;
    drive('0, {NS{3'd1}}, '1, '0);
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      drive(TAB[i].pend, TAB[i].prio, TAB[i].en, TAB[i].thr);
      @(posedge clk);
      @(negedge clk);
      check_both(tag[i], int'(TAB[i].id0), int'(TAB[i].id1));
      check_nt("R10");
    end

    // R10: row masked by threshold on t0 still wins without the check
    drive(5'b00011, {3'd1,3'd1,3'd1,3'd5,3'd3}, 10'h3FF, {3'd3,3'd5});
    @(posedge clk); @(negedge clk);
    chk("R10", "nothr id t0", int'(id_nt[0 +: IW]), 2);
    chk("R10", "nothr irq t0", int'(irq_nt[0]), 1);

    // R8: output holds old value until the next rising edge
    drive('0, {NS{3'd1}}, '1, '0);
    @(posedge clk); @(negedge clk);
    drive(5'b01000, {NS{3'd2}}, '1, '0);
    #1;
    chk("R8", "id before edge", int'(id[0 +: IW]), 0);
    @(posedge clk); @(negedge clk);
    chk("R8", "id after edge", int'(id[0 +: IW]), 4);

    // R7: winner claimed, next eligible source takes over, then line drops
    drive(5'b01010, {3'd1,3'd3,3'd1,3'd5,3'd1}, '1, '0);
    @(posedge clk); @(negedge clk);
    check_both("R7", 2, 2);
    pend = 5'b01000;
    @(posedge clk); @(negedge clk);
    check_both("R7", 4, 4);
    pend = 5'b00000;
    @(posedge clk); @(negedge clk);
    check_both("R7", 0, 0);

    // R9: asynchronous reset clears outputs without a clock edge
    pend = 5'b00001;
    @(posedge clk); @(negedge clk);
    chk("R9", "irq before reset", int'(irq[0]), 1);
    rst_n = 1'b0;
    #1;
    check_both("R9", 0, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    check_both("R6", 1, 1);

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

endmodule